// File: doc/BRIEF.md
# Precise Exception Entry and Return Controller

This block sits beside the write-back stage of a scalar in-order pipeline. It decides, in the first half of that stage, whether the instruction now retiring can commit or must be replaced by a trap. Each instruction reaches write-back carrying flags raised by earlier stages: a missing translation, an invalid translation, a write to a clean page, an arithmetic overflow and a system call. External interrupt lines are also sampled here and charged to the instruction in write-back. Because nothing is resolved earlier, only the oldest faulting instruction can take a trap. When a trap is taken the block stops that instruction's register write, tells the pipeline to squash it and every younger instruction, and steers fetch to a fixed handler address.

When a trap is taken, the block keeps a small two-level stack of mode and interrupt-enable bits. It records the restart PC, a 5-bit cause code and a delay-slot flag. A return instruction in write-back pops the stack and steers fetch back to the saved PC. A status-write instruction that retires without a trap loads all four stack bits. Handler code uses it to set up the state that a return will restore. All pins are plain control and status signals: the redirect is a single-cycle command that the fetch stage must accept, so no port has back-pressure.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the block is in kernel mode (`user_mode`=0) with interrupts disabled. Both saved stack bits are 0, and `epc`, `cause_code` and `bd_flag` are 0.
- R2: A trap is taken in a cycle when `wb_valid` is 1 and either any cause flag is set or an interrupt hit occurs. In that same cycle `squash` and `redirect_valid` are 1 and `rf_we_commit` is 0.
- R3: When several causes are present, the one taken follows this priority: interrupt, then translation missing, then translation invalid, then page modified, then overflow, then system call. The cause codes latched are 0, 2, 3, 1, 12 and 8 respectively.
- R4: A trap on a missing translation redirects to `VEC_BASE`. Every other trap redirects to `VEC_BASE`+0x080.
- R5: On the cycle after a trap, the previous-mode and previous-enable bits hold the values the current bits had before the trap. The block is in kernel mode with interrupts disabled.
- R6: On a trap, `epc` takes `wb_pc` and `bd_flag` takes 0. If `wb_in_dslot` is 1, `epc` takes `wb_pc`-4 and `bd_flag` takes 1.
- R7: An interrupt hit needs `int_enable`=1, `wb_valid`=1 and at least one `irq_lines` bit set. While `int_enable` is 0, pending lines cause no trap and leave all state unchanged.
- R8: A valid return instruction without a trap redirects to the current `epc` and raises `squash`. On the next cycle the current mode and enable bits equal the previous values before the return, and `epc` is unchanged.
- R9: A status write that retires without a trap and without a return loads `wb_st_data` bits [3:0] into previous-user, previous-enable, current-user and current-enable, in that order. A status write on a trapping instruction is dropped.
- R10: While `wb_valid` is 0, all cause flags, return and status-write inputs are ignored. No trap or redirect occurs, state holds, and `rf_we_commit` is 0.
- R11: A valid instruction with no trap passes `wb_rf_we` to `rf_we_commit` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_valid | input | 1 | A real instruction occupies write-back |
| wb_pc | input | PC_W | PC of the write-back instruction |
| wb_in_dslot | input | 1 | Instruction sits in a branch delay slot |
| wb_rf_we | input | 1 | Instruction wants to write the register file |
| wb_eret | input | 1 | Instruction is a return from trap |
| wb_st_wr | input | 1 | Instruction writes the mode stack |
| wb_st_data | input | 4 | Stack value {prev_user, prev_ie, user, ie} |
| wb_tlb_refill | input | 1 | No translation found for this instruction |
| wb_tlb_invalid | input | 1 | Translation found but marked invalid |
| wb_tlb_modified | input | 1 | Store to a page not marked writable-dirty |
| wb_overflow | input | 1 | Signed arithmetic overflow |
| wb_syscall | input | 1 | System call instruction |
| irq_lines | input | N_IRQ | External interrupt requests |
| rf_we_commit | output | 1 | Qualified register-file write enable |
| squash | output | 1 | Flush write-back and all younger stages |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Restart address |
| user_mode | output | 1 | Current mode, 1 = user |
| int_enable | output | 1 | Current interrupt enable |
| prev_user_mode | output | 1 | Saved mode |
| prev_int_enable | output | 1 | Saved interrupt enable |
| epc | output | PC_W | Saved restart PC |
| cause_code | output | 5 | Latched cause code |
| bd_flag | output | 1 | Trapped instruction was in a delay slot |

## Verification
A corrupt stack bit shows up on the `user_mode` or `int_enable` pins one cycle after the trap or return that wrote it. It also propagates: a later return restores the wrong mode, or an interrupt is taken or missed in a later cycle. A wrong priority choice shows at once on `redirect_pc` and, one cycle later, on `cause_code`. A wrong restart PC shows on `epc` one cycle after entry, and on `redirect_pc` at the next return. Comparing every output against a reference model on every clock catches each of these within one or two cycles of its cause.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NSRC = 6;

  // Request slots, lowest index wins
  localparam int SLOT_IRQ    = 0;
  localparam int SLOT_REFILL = 1;
  localparam int SLOT_INV    = 2;
  localparam int SLOT_MOD    = 3;
  localparam int SLOT_OVF    = 4;
  localparam int SLOT_SYS    = 5;

  typedef enum logic [4:0] {
    EXC_INT        = 5'd0,
    EXC_TLB_MOD    = 5'd1,
    EXC_TLB_REFILL = 5'd2,
    EXC_TLB_INV    = 5'd3,
    EXC_SYSCALL    = 5'd8,
    EXC_OVF        = 5'd12
  } exc_code_e;

  typedef struct packed {
    logic prev_user;
    logic prev_ie;
    logic cur_user;
    logic cur_ie;
  } mode_stack_t;

  function automatic exc_code_e slot_code(input int s);
    case (s)
      SLOT_IRQ:    return EXC_INT;
      SLOT_REFILL: return EXC_TLB_REFILL;
      SLOT_INV:    return EXC_TLB_INV;
      SLOT_MOD:    return EXC_TLB_MOD;
      SLOT_OVF:    return EXC_OVF;
      default:     return EXC_SYSCALL;
    endcase
  endfunction

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any,
  output exc_code_e    code
);

  // blocked[i] is set when a higher-priority slot is requesting
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pri
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];

  always_comb begin
    code = EXC_INT;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = slot_code(i);
    end
  end

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> ($countones(grant) == 1)) else $error("grant not single"); // R3
  AST_GRANT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0) else $error("grant without request"); // R3

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            ret,
  input  logic            st_wr,
  input  mode_stack_t     st_data,
  input  logic [PC_W-1:0] entry_pc,
  input  logic            entry_bd,
  input  exc_code_e       entry_code,
  output mode_stack_t     stk,
  output logic [PC_W-1:0] epc_q,
  output exc_code_e       cause_q,
  output logic            bd_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk     <= '0;
      epc_q   <= '0;
      cause_q <= EXC_INT;
      bd_q    <= 1'b0;
    end else if (take) begin
      stk.prev_user <= stk.cur_user;
      stk.prev_ie   <= stk.cur_ie;
      stk.cur_user  <= 1'b0;
      stk.cur_ie    <= 1'b0;
      epc_q         <= entry_pc;
      cause_q       <= entry_code;
      bd_q          <= entry_bd;
    end else if (ret) begin
      stk.cur_user <= stk.prev_user;
      stk.cur_ie   <= stk.prev_ie;
    end else if (st_wr) begin
      stk <= st_data;
    end
  end

  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!stk.cur_user && !stk.cur_ie)) else $error("entry not kernel"); // R5
  AST_ENTRY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (stk.prev_user == $past(stk.cur_user) && stk.prev_ie == $past(stk.cur_ie)))
    else $error("entry push lost"); // R5
  AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> (stk.cur_user == $past(stk.prev_user) && stk.cur_ie == $past(stk.prev_ie)))
    else $error("return pop wrong"); // R8
  AST_RET_EPC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |=> $stable(epc_q)) else $error("epc moved on return"); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !ret && !st_wr) |=> ($stable(stk) && $stable(epc_q) && $stable(bd_q)))
    else $error("state moved while idle"); // R10

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
  parameter int          PC_W     = 32,
  parameter logic [31:0] VEC_BASE = 32'h8000_0000,
  parameter logic [31:0] GEN_OFS  = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            ret,
  input  logic            refill,
  input  logic [PC_W-1:0] epc_q,
  output logic            rd_valid,
  output logic [PC_W-1:0] rd_pc
);

  localparam logic [PC_W-1:0] VEC_REFILL  = PC_W'(VEC_BASE);
  localparam logic [PC_W-1:0] VEC_GENERAL = PC_W'(VEC_BASE + GEN_OFS);

  always_comb begin
    rd_valid = take | ret;
    if (take) rd_pc = refill ? VEC_REFILL : VEC_GENERAL;
    else      rd_pc = epc_q;
  end

  AST_VEC_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && refill) |-> (rd_pc == VEC_REFILL)) else $error("refill vector"); // R4
  AST_RET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !take) |-> (rd_pc == epc_q)) else $error("return target"); // R8

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter int          N_IRQ      = 6,
  parameter int          INSN_BYTES = 4,
  parameter logic [31:0] VEC_BASE   = 32'h8000_0000,
  parameter logic [31:0] GEN_OFS    = 32'h0000_0080
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wb_valid,
  input  logic [PC_W-1:0]  wb_pc,
  input  logic             wb_in_dslot,
  input  logic             wb_rf_we,
  input  logic             wb_eret,
  input  logic             wb_st_wr,
  input  logic [3:0]       wb_st_data,
  input  logic             wb_tlb_refill,
  input  logic             wb_tlb_invalid,
  input  logic             wb_tlb_modified,
  input  logic             wb_overflow,
  input  logic             wb_syscall,
  input  logic [N_IRQ-1:0] irq_lines,
  output logic             rf_we_commit,
  output logic             squash,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             user_mode,
  output logic             int_enable,
  output logic             prev_user_mode,
  output logic             prev_int_enable,
  output logic [PC_W-1:0]  epc,
  output logic [4:0]       cause_code,
  output logic             bd_flag
);

  localparam logic [PC_W-1:0] SLOT_BYTES = PC_W'(INSN_BYTES);

  mode_stack_t       stk;
  logic [NSRC-1:0]   req, grant;
  logic              take, ret, irq_hit;
  exc_code_e         code, cause_q;
  logic [PC_W-1:0]   entry_pc, epc_q;
  logic              bd_q;

  assign irq_hit = wb_valid & stk.cur_ie & (|irq_lines);

  always_comb begin
    req              = '0;
    req[SLOT_IRQ]    = irq_hit;
    req[SLOT_REFILL] = wb_valid & wb_tlb_refill;
    req[SLOT_INV]    = wb_valid & wb_tlb_invalid;
    req[SLOT_MOD]    = wb_valid & wb_tlb_modified;
    req[SLOT_OVF]    = wb_valid & wb_overflow;
    req[SLOT_SYS]    = wb_valid & wb_syscall;
  end

  exc_cause_sel #(.N(NSRC)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .any   (take),
    .code  (code)
  );

  assign ret      = wb_valid & wb_eret & ~take;
  assign entry_pc = wb_in_dslot ? (wb_pc - SLOT_BYTES) : wb_pc;

  exc_status_regs #(.PC_W(PC_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .ret        (ret),
    .st_wr      (wb_valid & wb_st_wr),
    .st_data    (mode_stack_t'(wb_st_data)),
    .entry_pc   (entry_pc),
    .entry_bd   (wb_in_dslot),
    .entry_code (code),
    .stk        (stk),
    .epc_q      (epc_q),
    .cause_q    (cause_q),
    .bd_q       (bd_q)
  );

  exc_vector_sel #(
    .PC_W     (PC_W),
    .VEC_BASE (VEC_BASE),
    .GEN_OFS  (GEN_OFS)
  ) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .ret      (ret),
    .refill   (grant[SLOT_REFILL]),
    .epc_q    (epc_q),
    .rd_valid (redirect_valid),
    .rd_pc    (redirect_pc)
  );

  assign squash          = take | ret;
  assign rf_we_commit    = wb_valid & wb_rf_we & ~take;
  assign user_mode       = stk.cur_user;
  assign int_enable      = stk.cur_ie;
  assign prev_user_mode  = stk.prev_user;
  assign prev_int_enable = stk.prev_ie;
  assign epc             = epc_q;
  assign cause_code      = cause_q;
  assign bd_flag         = bd_q;

  AST_NO_COMMIT_ON_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid && !wb_eret |-> !rf_we_commit) else $error("write on trap"); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_enable && !wb_tlb_refill && !wb_tlb_invalid && !wb_tlb_modified
     && !wb_overflow && !wb_syscall && !wb_eret) |-> !redirect_valid)
    else $error("masked irq taken"); // R7
  AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_valid |-> (!redirect_valid && !squash && !rf_we_commit))
    else $error("activity without valid"); // R10
  AST_DSLOT_EPC: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !wb_eret && wb_in_dslot) |=> (bd_flag && epc == $past(wb_pc) - SLOT_BYTES))
    else $error("delay slot epc"); // R6

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  localparam int          N_IRQ = 6;
  localparam logic [31:0] BASE  = 32'h8000_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic wb_valid, wb_in_dslot, wb_rf_we, wb_eret, wb_st_wr;
  logic [31:0] wb_pc;
  logic [3:0] wb_st_data;
  logic f_ref, f_inv, f_mod, f_ovf, f_sys;
  logic [N_IRQ-1:0] irq;
  logic rf_we_commit, squash, redirect_valid, user_mode, int_enable;
  logic prev_user_mode, prev_int_enable, bd_flag;
  logic [31:0] redirect_pc, epc;
  logic [4:0] cause_code;

  exc_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_pc(wb_pc),
    .wb_in_dslot(wb_in_dslot), .wb_rf_we(wb_rf_we), .wb_eret(wb_eret),
    .wb_st_wr(wb_st_wr), .wb_st_data(wb_st_data),
    .wb_tlb_refill(f_ref), .wb_tlb_invalid(f_inv), .wb_tlb_modified(f_mod),
    .wb_overflow(f_ovf), .wb_syscall(f_sys), .irq_lines(irq),
    .rf_we_commit(rf_we_commit), .squash(squash), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .user_mode(user_mode), .int_enable(int_enable),
    .prev_user_mode(prev_user_mode), .prev_int_enable(prev_int_enable),
    .epc(epc), .cause_code(cause_code), .bd_flag(bd_flag)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  bit m_cu, m_ci, m_pu, m_pi, m_bd;
  int unsigned m_epc;
  int m_cause;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_state();
    chk("R5 user_mode", 32'(user_mode), 32'(m_cu));
    chk("R5 int_enable", 32'(int_enable), 32'(m_ci));
    chk("R5 prev_user", 32'(prev_user_mode), 32'(m_pu));
    chk("R5 prev_ie", 32'(prev_int_enable), 32'(m_pi));
    chk("R6 epc", epc, m_epc);
    chk("R6 bd_flag", 32'(bd_flag), 32'(m_bd));
    chk("R3 cause_code", 32'(cause_code), 32'(m_cause));
  endtask

  task automatic idle();
    wb_valid = 0; wb_pc = '0; wb_in_dslot = 0; wb_rf_we = 0; wb_eret = 0;
    wb_st_wr = 0; wb_st_data = '0; f_ref = 0; f_inv = 0; f_mod = 0;
    f_ovf = 0; f_sys = 0; irq = '0;
  endtask

  // inputs already driven at the falling edge; compare, advance model
  task automatic step();
    bit hit, tk, rt;
    int code;
    int unsigned vec;
    #5;
    hit = wb_valid && m_ci && (irq != 0);
    tk  = wb_valid && (hit || f_ref || f_inv || f_mod || f_ovf || f_sys);
    rt  = wb_valid && wb_eret && !tk;
    if (hit)        code = 0;
    else if (f_ref) code = 2;
    else if (f_inv) code = 3;
    else if (f_mod) code = 1;
    else if (f_ovf) code = 12;
    else            code = 8;
    vec = (code == 2) ? BASE : BASE + 32'h80;
    chk_state();
    chk("R2 squash", 32'(squash), 32'(tk || rt));
    chk("R2 redirect_valid", 32'(redirect_valid), 32'(tk || rt));
    chk("R11 R10 rf_we_commit", 32'(rf_we_commit), 32'(wb_valid && wb_rf_we && !tk));
    if (tk)      chk("R4 R3 redirect_pc", redirect_pc, vec);
    else if (rt) chk("R8 redirect_pc", redirect_pc, m_epc);
    if (tk) begin
      m_pu = m_cu; m_pi = m_ci; m_cu = 0; m_ci = 0;
      m_epc = wb_in_dslot ? wb_pc - 4 : wb_pc;
      m_bd = wb_in_dslot; m_cause = code;
    end else if (rt) begin
      m_cu = m_pu; m_ci = m_pi;
    end else if (wb_valid && wb_st_wr) begin
      {m_pu, m_pi, m_cu, m_ci} = wb_st_data;
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    m_cu = 0; m_ci = 0; m_pu = 0; m_pi = 0; m_bd = 0; m_epc = 0; m_cause = 0;
    repeat (3) @(negedge clk);
    chk_state(); // R1 reset state
    rst_n = 1;
    @(negedge clk);

    // R11 plain retire with write
    wb_valid = 1; wb_pc = 32'h100; wb_rf_we = 1; step();
    // R10 flags without valid are ignored
    idle(); f_sys = 1; f_ovf = 1; wb_eret = 1; wb_st_wr = 1; wb_st_data = 4'hF; wb_rf_we = 1; step();
    // R2 R6 system call, plain slot
    idle(); wb_valid = 1; wb_pc = 32'h200; f_sys = 1; wb_rf_we = 1; step();
    // R9 status write: prev user, prev ie, kernel, ie off
    idle(); wb_valid = 1; wb_st_wr = 1; wb_st_data = 4'b1100; step();
    // R8 return pops to user with ie on
    idle(); wb_valid = 1; wb_eret = 1; step();
    // R7 R3 interrupt with enable set, plus overflow: interrupt wins
    idle(); wb_valid = 1; wb_pc = 32'h340; irq = 6'b000100; f_ovf = 1; step();
    // R7 masked interrupt now has no effect
    idle(); wb_valid = 1; wb_pc = 32'h344; irq = 6'b111111; wb_rf_we = 1; step();
    // R4 R6 refill in a delay slot
    idle(); wb_valid = 1; wb_pc = 32'h500; wb_in_dslot = 1; f_ref = 1; f_mod = 1; step();
    // R9 status write dropped on trapping instruction
    idle(); wb_valid = 1; wb_st_wr = 1; wb_st_data = 4'b1111; f_inv = 1; step();
    // R8 return restores
    idle(); wb_valid = 1; wb_eret = 1; step();
    // R3 modified vs overflow vs syscall
    idle(); wb_valid = 1; wb_pc = 32'h600; f_mod = 1; f_ovf = 1; f_sys = 1; step();

    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      idle();
      wb_valid    = (r[3:0] != 0);
      wb_pc       = {$urandom} & 32'hFFFF_FFFC;
      wb_in_dslot = r[4] & r[5];
      wb_rf_we    = r[6];
      wb_eret     = (r[11:7] == 0);
      wb_st_wr    = (r[15:12] == 0);
      wb_st_data  = r[19:16];
      f_ref       = (r[23:20] == 0);
      f_inv       = (r[23:20] == 1);
      f_mod       = (r[23:20] == 2) || (r[27:24] == 3);
      f_ovf       = (r[23:20] == 3);
      f_sys       = (r[23:20] == 4);
      irq         = (r[27:24] < 3) ? N_IRQ'($urandom) : '0;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule